// File: doc/BRIEF.md
# Sparse Spike Fan-out Router

The router sits between an address-event spike source and a bank of dendritic branches. Each incoming event carries only the index of the input line that fired. The router expands it into the list of branch addresses that this input is wired to and streams them out one per cycle. Connectivity is sparse, so the wiring is not kept as a full input-by-branch bit matrix. It is kept in two compact tables, in the style of a compressed-sparse-row lookup. The offset table holds one start offset per input. The target table holds the branch addresses of all connections, packed back to back and grouped by input.

For an event on input `i`, the router reads offset entries `i` and `i+1`. These give the half-open slot range `[start, end)` in the target table. The router then streams those slots out in order. The end offset of the highest input is not stored: it is the total slot count `N_BRANCH*N_SYN`. The offset table therefore has `N_IN` entries of `$clog2(N_BRANCH*N_SYN)` bits, and the target table has `N_BRANCH*N_SYN` entries of `$clog2(N_BRANCH)` bits. Both tables are written through plain synchronous configuration ports while the router is idle.

The controller is a four-state machine:
- `ST_IDLE` waits for an event. It moves to `ST_PTR_LO` on acceptance.
- `ST_PTR_LO` captures the start offset and moves to `ST_PTR_HI`.
- `ST_PTR_HI` forms the end offset. It moves to `ST_EMIT` when the range is non-empty and back to `ST_IDLE` when it is empty.
- `ST_EMIT` presents one destination per cycle. It returns to `ST_IDLE` when the final destination is taken.

Top module: `fanout_router`

## Requirements
- R1: `in_ready` is high exactly while the router is idle, and an event is accepted on a cycle with `in_valid && in_ready`. After acceptance, `in_ready` stays low until the event is fully handled.
- R2: For an event on input `i`, the start offset is offset entry `i`. The end offset is offset entry `i+1`, except for input `N_IN-1`, whose end offset is fixed at `N_BRANCH*N_SYN` (12 by default).
- R3: When end > start, exactly end − start destinations are emitted: target table slots start, start+1, …, end−1, in that order, on `out_dest`.
- R4: When end ≤ start, the event produces no output at all, and the router becomes ready again.
- R5: `out_last` is high only on the final destination of an event. `out_src` carries the input index of the event being served.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_dest`, `out_last` and `out_src` keep their values. The slot index advances only on a completed transfer.
- R7: With `out_ready` held high, the destinations of one event leave on consecutive cycles, one per cycle.
- R8: Configuration writes update the addressed table entry on the clock edge when the router is idle. Writes presented while it is busy are discarded.
- R9: After reset, the router is idle, with `in_ready` high and `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming event present |
| in_ready | output | 1 | Router can take an event |
| in_addr | input | $clog2(N_IN) | Input index of the event |
| out_valid | output | 1 | Destination present |
| out_ready | input | 1 | Consumer takes the destination |
| out_dest | output | $clog2(N_BRANCH) | Destination branch address |
| out_last | output | 1 | Final destination of this event |
| out_src | output | $clog2(N_IN) | Input index being served |
| cfg_ptr_we | input | 1 | Offset table write strobe |
| cfg_ptr_addr | input | $clog2(N_IN) | Offset table write index |
| cfg_ptr_data | input | $clog2(N_BRANCH*N_SYN) | Start offset to store |
| cfg_dend_we | input | 1 | Target table write strobe |
| cfg_dend_addr | input | $clog2(N_BRANCH*N_SYN) | Target table write slot |
| cfg_dend_data | input | $clog2(N_BRANCH) | Branch address to store |

## Verification
The assertions take for granted that the stored offsets never exceed the slot count. This keeps every slot index that the controller walks inside the target table. The bench only loads offset values between 0 and 12. `out_ready` may fall on any cycle, and the bench throttles it with a fixed pattern to exercise the hold rule. The bench also presents configuration writes while the router is busy, and checks at the output that those writes had no effect.

// File: rtl/fanout_pkg.sv
package fanout_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PTR_LO,
        ST_PTR_HI,
        ST_EMIT
    } fan_state_e;

endpackage

// File: rtl/fanout_ram.sv
module fanout_ram #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 4,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (int'(waddr) < DEPTH)) begin
            mem[waddr] <= wdata;
        end
        if (re && (int'(raddr) < DEPTH)) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/fanout_ctrl.sv
module fanout_ctrl
    import fanout_pkg::*;
#(
    parameter int N_IN   = 8,
    parameter int N_SLOT = 12,
    localparam int IW = $clog2(N_IN),
    localparam int PW = $clog2(N_SLOT),
    localparam int EW = $clog2(N_SLOT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [IW-1:0] in_addr,
    output logic          out_valid,
    input  logic          out_ready,
    output logic          out_last,
    output logic [IW-1:0] out_src,
    output logic          idle,
    output logic          ptr_re,
    output logic [IW-1:0] ptr_raddr,
    input  logic [PW-1:0] ptr_rdata,
    output logic          dend_re,
    output logic [PW-1:0] dend_raddr
);

    fan_state_e state, state_nx;
    logic [IW-1:0] ev_addr;
    logic [PW-1:0] start_q;
    logic [EW-1:0] end_q;
    logic [PW-1:0] cur_q;

    logic [EW-1:0] hi_val;
    logic          nonempty;
    logic          fire;
    logic          is_last;
    logic          top_input;

    assign top_input = (ev_addr == IW'(N_IN - 1));
    assign hi_val    = top_input ? EW'(N_SLOT) : EW'(ptr_rdata);
    assign nonempty  = hi_val > EW'(start_q);
    assign is_last   = (EW'(cur_q) + EW'(1)) == end_q;
    assign fire      = (state == ST_EMIT) && out_ready;

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ev_addr <= '0;
            start_q <= '0;
            end_q   <= '0;
            cur_q   <= '0;
        end else begin
            state <= state_nx;
            unique case (state)
                ST_IDLE: begin
                    if (in_valid) ev_addr <= in_addr;
                end
                ST_PTR_LO: begin
                    start_q <= ptr_rdata;
                end
                ST_PTR_HI: begin
                    end_q <= hi_val;
                    cur_q <= start_q;
                end
                ST_EMIT: begin
                    if (fire && !is_last) cur_q <= cur_q + 1'b1;
                end
            endcase
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (in_valid) state_nx = ST_PTR_LO;
            ST_PTR_LO: state_nx = ST_PTR_HI;
            ST_PTR_HI: state_nx = nonempty ? ST_EMIT : ST_IDLE;
            ST_EMIT:   if (fire && is_last) state_nx = ST_IDLE;
        endcase
    end

    // outputs and memory read controls
    always_comb begin
        idle       = (state == ST_IDLE);
        in_ready   = idle;
        out_valid  = (state == ST_EMIT);
        out_last   = (state == ST_EMIT) && is_last;
        out_src    = ev_addr;
        ptr_re     = 1'b0;
        ptr_raddr  = ev_addr + 1'b1;
        dend_re    = 1'b0;
        dend_raddr = cur_q + 1'b1;
        unique case (state)
            ST_IDLE: begin
                ptr_re    = in_valid;
                ptr_raddr = in_addr;
            end
            ST_PTR_LO: begin
                ptr_re = !top_input;
            end
            ST_PTR_HI: begin
                dend_re    = nonempty;
                dend_raddr = start_q;
            end
            ST_EMIT: begin
                dend_re = fire && !is_last;
            end
        endcase
    end

    AST_ACCEPT_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);                                   // R1
    AST_EMPTY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PTR_HI && !nonempty) |=> (in_ready && !out_valid));         // R4
    AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> !out_valid);                    // R5
    AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (EW'(cur_q) < end_q));                                     // R3

endmodule

// File: rtl/fanout_router.sv
module fanout_router
    import fanout_pkg::*;
#(
    parameter int N_IN     = 8,
    parameter int N_BRANCH = 4,
    parameter int N_SYN    = 3,
    localparam int N_SLOT = N_BRANCH * N_SYN,
    localparam int IW = $clog2(N_IN),
    localparam int PW = $clog2(N_SLOT),
    localparam int BW = $clog2(N_BRANCH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [IW-1:0] in_addr,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [BW-1:0] out_dest,
    output logic          out_last,
    output logic [IW-1:0] out_src,
    input  logic          cfg_ptr_we,
    input  logic [IW-1:0] cfg_ptr_addr,
    input  logic [PW-1:0] cfg_ptr_data,
    input  logic          cfg_dend_we,
    input  logic [PW-1:0] cfg_dend_addr,
    input  logic [BW-1:0] cfg_dend_data
);

    logic          idle;
    logic          ptr_re;
    logic [IW-1:0] ptr_raddr;
    logic [PW-1:0] ptr_rdata;
    logic          dend_re;
    logic [PW-1:0] dend_raddr;
    logic [BW-1:0] dend_rdata;

    fanout_ctrl #(.N_IN(N_IN), .N_SLOT(N_SLOT)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_addr    (in_addr),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_last   (out_last),
        .out_src    (out_src),
        .idle       (idle),
        .ptr_re     (ptr_re),
        .ptr_raddr  (ptr_raddr),
        .ptr_rdata  (ptr_rdata),
        .dend_re    (dend_re),
        .dend_raddr (dend_raddr)
    );

    fanout_ram #(.DEPTH(N_IN), .WIDTH(PW)) u_offsets (
        .clk   (clk),
        .we    (cfg_ptr_we && idle),
        .waddr (cfg_ptr_addr),
        .wdata (cfg_ptr_data),
        .re    (ptr_re),
        .raddr (ptr_raddr),
        .rdata (ptr_rdata)
    );

    fanout_ram #(.DEPTH(N_SLOT), .WIDTH(BW)) u_targets (
        .clk   (clk),
        .we    (cfg_dend_we && idle),
        .waddr (cfg_dend_addr),
        .wdata (cfg_dend_data),
        .re    (dend_re),
        .raddr (dend_raddr),
        .rdata (dend_rdata)
    );

    assign out_dest = dend_rdata;

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_dest)
            && $stable(out_last) && $stable(out_src)));                          // R6

endmodule

// File: tb/tb_fanout_router.sv
`timescale 1ns/1ps
module tb_fanout_router;

    localparam int N_IN = 8, N_BRANCH = 4, N_SYN = 3;
    localparam int N_SLOT = N_BRANCH * N_SYN;
    localparam int IW = $clog2(N_IN), PW = $clog2(N_SLOT), BW = $clog2(N_BRANCH);

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid, in_ready, out_valid, out_ready, out_last;
    logic [IW-1:0] in_addr, out_src, cfg_ptr_addr;
    logic [BW-1:0] out_dest, cfg_dend_data;
    logic cfg_ptr_we, cfg_dend_we;
    logic [PW-1:0] cfg_ptr_data, cfg_dend_addr;

    int vectors = 0;
    int errors  = 0;
    int ptr_m [N_IN];
    int dend_m [N_SLOT];

    always #2 clk = ~clk;

    fanout_router #(.N_IN(N_IN), .N_BRANCH(N_BRANCH), .N_SYN(N_SYN)) dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
        .out_valid(out_valid), .out_ready(out_ready), .out_dest(out_dest),
        .out_last(out_last), .out_src(out_src),
        .cfg_ptr_we(cfg_ptr_we), .cfg_ptr_addr(cfg_ptr_addr), .cfg_ptr_data(cfg_ptr_data),
        .cfg_dend_we(cfg_dend_we), .cfg_dend_addr(cfg_dend_addr), .cfg_dend_data(cfg_dend_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_cfg(input int cfg);
        int st [4][N_IN] = '{'{0, 2, 2, 3, 6, 6, 8, 9},
                             '{0, 12, 12, 12, 12, 12, 12, 12},
                             '{5, 5, 5, 5, 5, 5, 5, 5},
                             '{4, 2, 2, 6, 6, 6, 10, 11}};
        for (int i = 0; i < N_IN; i++) begin
            ptr_m[i] = st[cfg][i];
            @(negedge clk);
            cfg_ptr_we = 1'b1; cfg_ptr_addr = IW'(i); cfg_ptr_data = PW'(ptr_m[i]);
        end
        for (int s = 0; s < N_SLOT; s++) begin
            dend_m[s] = (s * (cfg + 1) + s / 4) % N_BRANCH;
            @(negedge clk);
            cfg_ptr_we = 1'b0;
            cfg_dend_we = 1'b1; cfg_dend_addr = PW'(s); cfg_dend_data = BW'(dend_m[s]);
        end
        @(negedge clk);
        cfg_ptr_we = 1'b0; cfg_dend_we = 1'b0;
    endtask

    task automatic run_event(input int i, input bit bp, input bit poke);
        int s, e, n, got, cyc;
        bit hold, rdy;
        logic [BW-1:0] held;
        string dlabel;
        s = ptr_m[i];
        e = (i == N_IN - 1) ? N_SLOT : ptr_m[i + 1];
        n = (e > s) ? e - s : 0;
        dlabel = poke ? "R8 busy write ignored" : "R2 R3 dest order";
        @(negedge clk);
        chk(in_ready === 1'b1, "R1 ready while idle", int'(in_ready), 1);
        in_valid = 1'b1; in_addr = IW'(i);
        @(negedge clk);
        in_valid = 1'b0;
        chk(in_ready === 1'b0, "R1 busy after accept", int'(in_ready), 0);
        if (poke) begin
            cfg_dend_we = 1'b1; cfg_dend_addr = PW'(s % N_SLOT);
            cfg_dend_data = ~BW'(dend_m[s % N_SLOT]);
            cfg_ptr_we = 1'b1; cfg_ptr_addr = IW'((i + 1) % N_IN); cfg_ptr_data = '0;
            @(negedge clk);
            cfg_dend_we = 1'b0; cfg_ptr_we = 1'b0;
        end
        got = 0; cyc = 0; hold = 1'b0; held = '0;
        while (got < n && cyc < 100) begin
            if (hold)
                chk(out_valid === 1'b1 && out_dest === held, "R6 stable under backpressure",
                    int'(out_dest), int'(held));
            if (!bp && got > 0)
                chk(out_valid === 1'b1, "R7 one per cycle", int'(out_valid), 1);
            rdy = bp ? ((cyc % 3) != 1) : 1'b1;
            hold = 1'b0;
            if (out_valid === 1'b1) begin
                chk(in_ready === 1'b0, "R1 no accept while emitting", int'(in_ready), 0);
                if (rdy) begin
                    chk(out_dest === BW'(dend_m[s + got]), dlabel, int'(out_dest), dend_m[s + got]);
                    chk(out_last === (got == n - 1), "R5 last flag", int'(out_last), int'(got == n - 1));
                    chk(out_src === IW'(i), "R5 source index", int'(out_src), i);
                    got++;
                end else begin
                    hold = 1'b1;
                    held = out_dest;
                end
            end
            out_ready = rdy;
            @(negedge clk);
            cyc++;
        end
        out_ready = 1'b0;
        chk(got == n, "R3 destination count", got, n);
        for (int w = 0; w < 4; w++) begin
            chk(out_valid === 1'b0, n == 0 ? "R4 empty gives nothing" : "R3 no extra output",
                int'(out_valid), 0);
            @(negedge clk);
        end
        chk(in_ready === 1'b1, "R4 ready again", int'(in_ready), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        vectors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        in_valid = 1'b0; in_addr = '0; out_ready = 1'b0;
        cfg_ptr_we = 1'b0; cfg_ptr_addr = '0; cfg_ptr_data = '0;
        cfg_dend_we = 1'b0; cfg_dend_addr = '0; cfg_dend_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid === 1'b0, "R9 reset out_valid", int'(out_valid), 0);
        chk(in_ready === 1'b1, "R9 reset in_ready", int'(in_ready), 1);

        for (int cfg = 0; cfg < 4; cfg++) begin
            load_cfg(cfg);
            for (int i = 0; i < N_IN; i++) begin
                run_event(i, 1'b0, 1'b0);
                run_event(i, 1'b1, 1'b0);
            end
        end

        // R8: writes during a busy event are dropped; tables stay as loaded
        load_cfg(0);
        run_event(3, 1'b1, 1'b1);
        run_event(1, 1'b0, 1'b1);
        run_event(3, 1'b0, 1'b0);
        run_event(2, 1'b0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule